// File: doc/BRIEF.md
# Low-speed USB packet serialiser

This block drives one packet onto a differential D+/D- pair at a fixed number of clocks per bit, twelve by default. A single start pulse latches how many bytes follow the sync byte. The block then takes control of the bus through an output enable and drives one bit of idle J. It sends the sync byte and then pulls each further byte through a ready/valid port. Every byte goes out least significant bit first, NRZI-encoded, and a stuff bit is inserted after every run of six ones.

When the last byte is out, the block drives SE0 for two bit times and J for one bit time. It then releases both lines. A one-cycle completion pulse carries two flags: whether the packet was a data packet or a two-byte handshake, and whether it was cut short because the byte source ran dry. A pending device address is copied into the active address register only when a data packet completes without error. CRC generation and payload content are left to the logic that feeds the byte port.

Top module: `usb_ls_tx`

## Requirements
- R1: After reset, drv_en, busy, tx_ready, done, dp_out, dm_out and dev_addr are all 0. A start pulse seen while idle raises drv_en and busy in the next cycle, and the lines then show J (dp_out=0, dm_out=1) for one bit time before the first sync bit. busy stays high until release.
- R2: Every line symbol (J, K or SE0) lasts exactly CLKS_PER_BIT clock cycles. K is dp_out=1, dm_out=0, and SE0 is both lines low.
- R3: The first byte on the wire is 0x80, least significant bit first: seven toggles followed by one held bit.
- R4: NRZI coding is used. A 1 keeps the previous line state and a 0 toggles both lines. Bytes are sent in the order they were accepted, each least significant bit first.
- R5: After six consecutive 1 bits, one extra toggle is inserted and the run count restarts. This applies after any bit position, including bit 7, and runs that cross a byte boundary are counted. The run count starts at zero with the sync byte.
- R6: After the last bit (and any stuff bit it requires), SE0 lasts two bit times and J lasts one bit time. Then drv_en, busy, dp_out and dm_out fall together, and done pulses high for exactly one cycle.
- R7: byte_count is the number of bytes after sync. With done, done_data is 0 when byte_count is 1 (handshake) and 1 when byte_count is 2 or more.
- R8: dev_addr takes new_addr at the completion of a packet only when done_data is 1 and done_err is 0. Otherwise it keeps its value.
- R9: tx_ready is high only during bit 7 of the byte being sent, or the stuff bit that follows it, while more bytes remain and none is held. A byte is taken on a cycle with tx_ready and tx_valid both high, and exactly the needed number of bytes is taken.
- R10: If bit 7 finishes while bytes remain and none has been delivered, SE0 starts in the next bit slot. The packet then ends as in R6 with done_err=1.
- R11: start is ignored while busy. The packet in progress continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a packet (sampled only when idle) |
| byte_count | input | CNT_W | Bytes following sync |
| tx_data | input | 8 | Next byte to send |
| tx_valid | input | 1 | tx_data is valid |
| tx_ready | output | 1 | Block will take tx_data this cycle |
| new_addr | input | ADDR_W | Pending device address |
| dev_addr | output | ADDR_W | Active device address |
| dp_out | output | 1 | D+ level |
| dm_out | output | 1 | D- level |
| drv_en | output | 1 | Output enable for both lines |
| busy | output | 1 | Bus held from acquire to release |
| done | output | 1 | One-cycle completion pulse |
| done_data | output | 1 | Last packet was a data packet |
| done_err | output | 1 | Last packet was aborted by underrun |

## Verification
The embedded properties assume that start arrives only with a stable byte_count and that the address input does not matter outside the completion cycle. They do not constrain tx_valid, so underrun remains a legal input case. The stimulus holds tx_valid high while bytes remain in its supply. It withholds tx_valid on purpose in the underrun case, and it pulses start in the middle of a packet to show that the request is dropped. A behavioural model rebuilds the expected symbol stream from the byte list, including stuff bits and early termination, and compares the lines on every clock.

// File: rtl/usb_ls_tx.sv
`timescale 1ns/1ps
module usb_ls_tx #(
  parameter int CLKS_PER_BIT = 12,
  parameter int CNT_W        = 8,
  parameter int ADDR_W       = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  byte_count,
  input  logic [7:0]        tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [ADDR_W-1:0] new_addr,
  output logic [ADDR_W-1:0] dev_addr,
  output logic              dp_out,
  output logic              dm_out,
  output logic              drv_en,
  output logic              busy,
  output logic              done,
  output logic              done_data,
  output logic              done_err
);
  localparam int TW = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
  localparam logic [TW-1:0] TMAX = TW'(CLKS_PER_BIT - 1);

  typedef enum logic [2:0] {ST_IDLE, ST_LEAD, ST_BITS, ST_EOP, ST_TAIL} st_t;

  st_t              st;
  logic [TW-1:0]    tmr;
  logic [7:0]       sh, nxt;
  logic [2:0]       bitix, ones;
  logic             line_k, have_nxt, eop_n, data_pkt, err;
  logic [CNT_W-1:0] rem;

  wire       tick  = (tmr == TMAX);
  assign tx_ready  = (st == ST_BITS) && (bitix == 3'd7) && (rem != '0) && !have_nxt;
  wire       take  = tx_ready && tx_valid;
  wire [7:0] src   = have_nxt ? nxt : tx_data;
  wire       avail = have_nxt || take;
  wire       nbit  = (st == ST_LEAD) ? sh[0] :
                     (bitix != 3'd7) ? sh[bitix + 3'd1] : src[0];

  assign drv_en = (st != ST_IDLE);
  assign busy   = drv_en;
  assign dp_out = drv_en && (st != ST_EOP) && line_k;
  assign dm_out = drv_en && (st != ST_EOP) && !line_k;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE; tmr <= '0; sh <= '0; nxt <= '0; bitix <= '0; ones <= '0;
      line_k <= 1'b0; have_nxt <= 1'b0; eop_n <= 1'b0; data_pkt <= 1'b0;
      err <= 1'b0; rem <= '0; done <= 1'b0; done_data <= 1'b0; done_err <= 1'b0;
      dev_addr <= '0;
    end else begin
      done <= 1'b0;
      if (take) begin
        nxt <= tx_data;
        have_nxt <= 1'b1;
      end
      if (st != ST_IDLE) tmr <= tick ? '0 : tmr + 1'b1;
      case (st)
        ST_IDLE: if (start) begin
          st <= ST_LEAD; tmr <= '0; line_k <= 1'b0; ones <= '0; sh <= 8'h80;
          bitix <= '0; rem <= byte_count; have_nxt <= 1'b0; err <= 1'b0;
          data_pkt <= (byte_count >= CNT_W'(2)); eop_n <= 1'b0;
        end
        ST_LEAD: if (tick) begin
          st <= ST_BITS;
          line_k <= nbit ? line_k : !line_k;
          ones <= nbit ? ones + 3'd1 : 3'd0;
        end
        ST_BITS: if (tick) begin
          if (ones == 3'd6) begin
            line_k <= !line_k;
            ones <= '0;
          end else if (bitix != 3'd7) begin
            bitix <= bitix + 3'd1;
            line_k <= nbit ? line_k : !line_k;
            ones <= nbit ? ones + 3'd1 : 3'd0;
          end else if (rem == '0) begin
            st <= ST_EOP; eop_n <= 1'b0;
          end else if (avail) begin
            sh <= src; bitix <= '0; rem <= rem - 1'b1; have_nxt <= 1'b0;
            line_k <= nbit ? line_k : !line_k;
            ones <= nbit ? ones + 3'd1 : 3'd0;
          end else begin
            st <= ST_EOP; eop_n <= 1'b0; err <= 1'b1;
          end
        end
        ST_EOP: if (tick) begin
          if (eop_n) begin
            st <= ST_TAIL; line_k <= 1'b0;
          end else eop_n <= 1'b1;
        end
        ST_TAIL: if (tick) begin
          st <= ST_IDLE; done <= 1'b1; done_data <= data_pkt; done_err <= err;
          if (data_pkt && !err) dev_addr <= new_addr;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R1
  acquire_j_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_en) |-> (dm_out && !dp_out));
  // R5
  run_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ones <= 3'd6);
  // R6
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!drv_en && $past(drv_en)));
  // R8
  addr_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dev_addr) |-> (done && done_data && !done_err));
  // R9
  ready_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> (busy && !done));
endmodule

// File: tb/test_usb_ls_tx.sv
`timescale 1ns/1ps
module test_usb_ls_tx;
  localparam int CPB = 12;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n, start, tx_valid, tx_ready;
  logic [7:0] byte_count, tx_data;
  logic [6:0] new_addr, dev_addr;
  logic       dp_out, dm_out, drv_en, busy, done, done_data, done_err;

  usb_ls_tx i_usb_ls_tx (
    .clk(clk), .rst_n(rst_n), .start(start), .byte_count(byte_count),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .new_addr(new_addr), .dev_addr(dev_addr), .dp_out(dp_out), .dm_out(dm_out),
    .drv_en(drv_en), .busy(busy), .done(done), .done_data(done_data), .done_err(done_err));

  int n_chk = 0, n_bad = 0;
  bit fin = 0;
  int sym_q[$];
  int tag_q[$];
  bit r7_q[$];
  logic [7:0] pkt[$];
  int line, ones;

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic push(int s, int t, bit r);
    sym_q.push_back(s); tag_q.push_back(t); r7_q.push_back(r);
  endtask

  task automatic enc_bit(bit v, int t, bit r);
    if (!v) line = 1 - line;
    push(line, t, r);
    if (v) ones++; else ones = 0;
    if (ones == 6) begin
      line = 1 - line;
      push(line, 5, r);
      ones = 0;
    end
  endtask

  function automatic string tagname(int t);
    case (t)
      1: return "R1 R2";
      3: return "R3 R2";
      5: return "R5 R2";
      6: return "R6 R2";
      default: return "R4 R2";
    endcase
  endfunction

  task automatic run_pkt(int count, int limit, logic [6:0] naddr, bit poke);
    int nfetch = (limit < count) ? limit : count;
    int idx = 0;
    bit acc = 0;
    logic [6:0] old_addr = dev_addr;
    logic [6:0] exp_addr;
    logic [7:0] b;
    int nsym, es, as;
    sym_q.delete(); tag_q.delete(); r7_q.delete();
    line = 0; ones = 0;
    push(0, 1, 0);
    for (int k = 0; k <= nfetch; k++) begin
      b = (k == 0) ? 8'h80 : pkt[k-1];
      for (int i = 0; i < 8; i++) enc_bit(b[i], (k == 0) ? 3 : 4, (i == 7) && (k < count));
    end
    push(2, 6, 0); push(2, 6, 0); push(0, 6, 0);
    nsym = sym_q.size();
    @(negedge clk);
    new_addr = naddr; byte_count = 8'(count);
    tx_valid = (nfetch > 0);
    tx_data = (pkt.size() > 0) ? pkt[0] : 8'h00;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int j = 0; j <= CPB * nsym; j++) begin
      if (j > 0) @(negedge clk);
      if (acc) idx++;
      acc = 0;
      if (j < CPB * nsym) begin
        es = sym_q[j / CPB];
        as = !drv_en ? 3 : (dp_out && !dm_out) ? 1 : (!dp_out && dm_out) ? 0 : (!dp_out && !dm_out) ? 2 : 4;
        chk(as == es, tagname(tag_q[j / CPB]), as, es);
        chk(busy && !done, "R1", {busy, done}, 2);
        if (tx_ready) chk(r7_q[j / CPB], "R9", 1, 0);
        if (j == 101 && poke) chk(busy, "R11", busy, 1);
      end else begin
        chk(!drv_en && !busy && !dp_out && !dm_out, "R6", {drv_en, busy, dp_out, dm_out}, 0);
        chk(done, "R6", done, 1);
        chk(done_data == (count >= 2), "R7", done_data, (count >= 2));
        chk(done_err == (limit < count), "R10", done_err, (limit < count));
        chk(idx == nfetch, "R9", idx, nfetch);
      end
      // R11: a start pulse mid-packet must leave the stream unchanged
      if (poke && j == 100) begin start = 1'b1; byte_count = 8'd1; end
      else begin start = 1'b0; byte_count = 8'(count); end
      tx_valid = (idx < nfetch);
      if (idx < nfetch) tx_data = pkt[idx];
      acc = tx_ready && tx_valid;
    end
    @(negedge clk);
    chk(!done, "R6", done, 0);
    exp_addr = (count >= 2 && limit >= count) ? naddr : old_addr;
    chk(dev_addr == exp_addr, "R8", dev_addr, exp_addr);
    repeat (5) @(negedge clk);
  endtask

  initial begin
    #4_000_000;
    if (!fin) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; tx_valid = 1'b0; tx_data = 8'h00;
    byte_count = 8'd0; new_addr = 7'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!drv_en && !busy && !tx_ready && !done && !dp_out && !dm_out, "R1",
        {drv_en, busy, tx_ready, done, dp_out, dm_out}, 0);
    chk(dev_addr == 7'h00, "R1", dev_addr, 0);

    // R7 R8: handshake packet, no address commit
    pkt = '{8'hD2};
    run_pkt(1, 1, 7'h15, 0);
    // R4 R5 R8: data packet with long runs of ones, address commits
    pkt = '{8'hC3, 8'hFF, 8'hFF, 8'h7E};
    run_pkt(4, 4, 7'h2A, 0);
    // R5: stuff after bit 7 and runs spanning byte boundaries; R11 poke
    pkt = '{8'h4B, 8'hFC, 8'h3F, 8'h80, 8'h1F};
    run_pkt(5, 5, 7'h33, 1);
    // R10: underrun after two bytes, address must not change
    pkt = '{8'h5A, 8'h01, 8'h77, 8'h00, 8'h00};
    run_pkt(5, 2, 7'h61, 0);
    // R4: zero-heavy data packet
    pkt = '{8'h00, 8'h81};
    run_pkt(2, 2, 7'h0C, 0);

    fin = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule